// File: doc/BRIEF.md
# Switchable Halfband Decimator for Complex Samples

This block lowers the sample rate of a complex baseband stream by 1, 2, 4 or 8. A two-bit rate control picks how many of its divide-by-two halfband stages carry the stream. The stages not picked are skipped and hold their state. Each 16-bit I and Q sample is first widened to 18 bits. It then passes through the active stages, where I and Q are filtered side by side by identical logic, and is narrowed back to 16 bits before it leaves.

Both the input and the output are valid/ready streams. An input sample is taken on a cycle where `in_valid` and `in_ready` are both high. An output sample is handed over on a cycle where `out_valid` and `out_ready` are both high. When the output register holds a sample that has not been taken, the whole datapath freezes. In that state `in_ready` is low and nothing inside moves. The rate control is a plain input. It should only be changed while no samples are in flight.

Top module: `hbd_cascade`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: With `rate` = 0 the block does not filter. A sample taken at one clock edge shows up unchanged on `out_i`/`out_q` with `out_valid` high right after the next edge.
- R3: With `rate` = k (1 to 3), k stages are in series and each stage passes on one result for every second sample it receives. The block therefore gives one output for every 2^k inputs taken, and never presents valid data on two cycles in a row.
- R4: A stage widens nothing and works on 18-bit values. When its phase is odd it outputs y = (16·x[n−3] + 9·(x[n−2] + x[n−4]) − x[n] − x[n−6]) >> 5, using an arithmetic shift that rounds toward minus infinity. Here x[n] is the sample just received, and the history starts at zero after reset.
- R5: On the way in, a 16-bit sample is shifted left by 2 into 18 bits. On the way out, the 2 least significant bits of the 18-bit result are dropped by an arithmetic shift right.
- R6: I and Q use the same stage logic and the same timing, and neither has any effect on the other.
- R7: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, the output values stay stable and no input is taken.
- R8: Any change of `rate` sets every stage's phase back to even. Filter histories are kept, and a stage that is not active does not update.
- R9: A stage result outside the 18-bit range is clamped to 131071 or −131072. After narrowing, these become 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate | input | 2 | Number of active stages (0 = pass-through) |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 18-bit filter words and three stages. With these values all four rate settings can be tested, as can the saturation corners of the 18-bit datapath. Separate I and Q streams are sent through every rate, with output back-pressure switched on in one run. A rate change in the middle of a stream checks that the phase is cleared while the filter history is kept. A crafted pattern drives the filter into both clamp limits.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int SMP_W   = 16;
  localparam int FLT_W   = 18;
  localparam int DEC_STG = 3;
  localparam int RATE_W  = 2;
  // halfband coefficient set, total gain 2**HB_SHIFT
  localparam int HB_CENTER = 16;
  localparam int HB_NEAR   = 9;
  localparam int HB_SHIFT  = 5;
  localparam int HB_HIST   = 6;
endpackage

// File: rtl/iq_pad.sv
module iq_pad #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 18
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - IN_W;
  assign dout = {din, {PAD{1'b0}}};
endmodule

// File: rtl/iq_trunc.sv
module iq_trunc #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int DROP = IN_W - OUT_W;
  assign dout = OUT_W'(din >>> DROP);
endmodule

// File: rtl/hbd_stage.sv
module hbd_stage
  import hbd_pkg::*;
#(
  parameter int W = FLT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                clr,
  input  logic                act,
  input  logic                v_in,
  input  logic signed [W-1:0] i_in,
  input  logic signed [W-1:0] q_in,
  output logic                v_out,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out
);
  localparam int SW = W + 7;
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(64'sd1 <<< (W - 1));

  logic phase, ph_eff, fire, take;
  assign ph_eff = clr ? 1'b0 : phase;
  assign fire   = en && act && v_in;
  assign take   = fire && ph_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      v_out <= 1'b0;
    end else begin
      if (clr) phase <= 1'b0;
      if (fire) phase <= !ph_eff;
      if (en) v_out <= take;
    end
  end

  logic signed [W-1:0] lane_in  [2];
  logic signed [W-1:0] lane_out [2];
  assign lane_in[0] = i_in;
  assign lane_in[1] = q_in;
  assign i_out = lane_out[0];
  assign q_out = lane_out[1];

  function automatic logic signed [SW-1:0] ext(input logic signed [W-1:0] v);
    return SW'(v);
  endfunction

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [W-1:0]  hist [HB_HIST];
    logic signed [SW-1:0] acc, scaled;
    logic signed [W-1:0]  clamped;

    always_comb begin
      acc = SW'(HB_NEAR) * (ext(hist[1]) + ext(hist[3]))
          + SW'(HB_CENTER) * ext(hist[2])
          - ext(lane_in[l]) - ext(hist[5]);
      scaled = acc >>> HB_SHIFT;
      if (scaled > MAXV)      clamped = W'(MAXV);
      else if (scaled < MINV) clamped = W'(MINV);
      else                    clamped = W'(scaled);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < HB_HIST; j++) hist[j] <= '0;
        lane_out[l] <= '0;
      end else if (fire) begin
        hist[0] <= lane_in[l];
        for (int j = 1; j < HB_HIST; j++) hist[j] <= hist[j-1];
        if (ph_eff) lane_out[l] <= clamped;
      end
    end
  end
endmodule

// File: rtl/hbd_cascade.sv
module hbd_cascade
  import hbd_pkg::*;
#(
  parameter int IN_W    = SMP_W,
  parameter int W       = FLT_W,
  parameter int N_STG   = DEC_STG,
  parameter int RSEL_W  = RATE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RSEL_W-1:0]      rate,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [IN_W-1:0] out_i,
  output logic signed [IN_W-1:0] out_q
);
  logic en, clr;
  logic [RSEL_W-1:0] rate_q;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign clr      = rate != rate_q;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= '0;
    else     rate_q <= rate;
  end

  logic                v_c [N_STG+1];
  logic signed [W-1:0] i_c [N_STG+1];
  logic signed [W-1:0] q_c [N_STG+1];

  assign v_c[0] = in_valid;
  iq_pad #(.IN_W(IN_W), .OUT_W(W)) u_pad_i (.din(in_i), .dout(i_c[0]));
  iq_pad #(.IN_W(IN_W), .OUT_W(W)) u_pad_q (.din(in_q), .dout(q_c[0]));

  for (genvar k = 0; k < N_STG; k++) begin : g_stg
    logic act;
    assign act = int'(rate) > k;
    hbd_stage #(.W(W)) u_stage (
      .clk(clk), .rst(rst), .en(en), .clr(clr), .act(act),
      .v_in(v_c[k]), .i_in(i_c[k]), .q_in(q_c[k]),
      .v_out(v_c[k+1]), .i_out(i_c[k+1]), .q_out(q_c[k+1])
    );
  end

  int                  sel;
  logic                v_sel;
  logic signed [W-1:0] i_sel, q_sel;
  logic signed [IN_W-1:0] i_nar, q_nar;

  always_comb begin
    sel   = (int'(rate) > N_STG) ? N_STG : int'(rate);
    v_sel = v_c[sel];
    i_sel = i_c[sel];
    q_sel = q_c[sel];
  end

  iq_trunc #(.IN_W(W), .OUT_W(IN_W)) u_trn_i (.din(i_sel), .dout(i_nar));
  iq_trunc #(.IN_W(W), .OUT_W(IN_W)) u_trn_q (.din(q_sel), .dout(q_nar));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (en) begin
      out_valid <= v_sel;
      out_i     <= i_nar;
      out_q     <= q_nar;
    end
  end
endmodule

// File: rtl/hbd_cascade_chk.sv
module hbd_cascade_chk #(
  parameter int IN_W   = 16,
  parameter int RSEL_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [RSEL_W-1:0]      rate,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic signed [IN_W-1:0] in_i,
  input logic signed [IN_W-1:0] in_q,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic signed [IN_W-1:0] out_i,
  input logic signed [IN_W-1:0] out_q
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (rate == '0 && in_valid && in_ready) |=>
      (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));

  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
    (rate != '0 && $stable(rate) && out_valid && out_ready) |=>
      (!out_valid || rate != $past(rate)));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_i) && $stable(out_q)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind hbd_cascade hbd_cascade_chk #(.IN_W(IN_W), .RSEL_W(RSEL_W)) u_chk (
  .clk(clk), .rst(rst), .rate(rate), .in_valid(in_valid), .in_ready(in_ready),
  .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
  .out_i(out_i), .out_q(out_q)
);

// File: tb/test_hbd_cascade.sv
module test_hbd_cascade;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rate = 2'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_i, out_q;

  always #4 clk = ~clk;

  hbd_cascade i_hbd_cascade (
    .clk(clk), .rst(rst), .rate(rate), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q)
  );

  int checks = 0, errors = 0, n_out = 0;
  bit done = 0, bp_on = 0;
  logic [31:0] sb [$];
  logic signed [15:0] last_i, last_q;
  int unsigned lcg = 32'h1234_5678;

  // reference model state: per stage, per lane
  int hist [3][2][6];
  bit phase [3];

  function automatic int sat18(input int v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      phase[k] = 0;
      for (int l = 0; l < 2; l++) for (int j = 0; j < 6; j++) hist[k][l][j] = 0;
    end
  endtask

  task automatic model_push(input int si, input int sq);
    int x [2];
    int y;
    x[0] = si * 4; x[1] = sq * 4;
    for (int k = 0; k < int'(rate); k++) begin
      bit emit;
      emit = phase[k];
      phase[k] = !phase[k];
      for (int l = 0; l < 2; l++) begin
        y = 16 * hist[k][l][2] + 9 * (hist[k][l][1] + hist[k][l][3])
            - x[l] - hist[k][l][5];
        y = sat18(y >>> 5);
        for (int j = 5; j > 0; j--) hist[k][l][j] = hist[k][l][j-1];
        hist[k][l][0] = x[l];
        x[l] = y;
      end
      if (!emit) return;
    end
    sb.push_back({16'(x[0] >>> 2), 16'(x[1] >>> 2)});
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int si, input int sq);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(si); in_q = 16'(sq);
    forever begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) begin model_push(si, sq); break; end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    bp_on = 0;
    idle(16);
    check(sb.size() == 0, "R3 drained", sb.size(), 0);
  endtask

  task automatic set_rate(input logic [1:0] r);
    @(negedge clk);
    rate = r;
    for (int k = 0; k < 3; k++) phase[k] = 0;
    @(negedge clk);
  endtask

  function automatic int nextv();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'($signed(lcg[31:16]));
  endfunction

  task automatic block(input logic [1:0] r, input int n);
    int base;
    set_rate(r);
    base = n_out;
    for (int s = 0; s < n; s++) send(nextv(), nextv());
    drain();
    check(n_out - base == (n >> r), "R3 output count", n_out - base, n >> r);
  endtask

  // monitor / scoreboard
  bit stalled = 0;
  logic signed [15:0] held_i, held_q;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        if (stalled)
          check(out_valid && out_i == held_i && out_q == held_q,
                "R7 hold during stall", out_i, held_i);
        if (out_valid && out_ready) begin
          n_out++;
          last_i = out_i; last_q = out_q;
          if (sb.size() == 0) check(0, "R4 unexpected output", out_i, 0);
          else begin
            logic [31:0] e;
            e = sb.pop_front();
            check({out_i, out_q} == e, "R4 R6 sample value", {out_i, out_q}, e);
          end
        end
        stalled = out_valid && !out_ready;
        held_i = out_i; held_q = out_q;
      end
    end
  end

  // back-pressure generator
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? (nextv() % 3 != 0) : 1'b1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    @(negedge clk) rst = 1'b0;
    #1;
    check(out_valid == 0 && in_ready == 1, "R1 after reset", out_valid, 0);

    // R2: bypass latency
    send(1234, -567);
    @(negedge clk);
    #1;
    check(out_valid == 1 && out_i == 1234 && out_q == -567, "R2 one-cycle bypass", out_i, 1234);
    in_valid = 1'b0;
    drain();

    // R5 identity at rate 0, R3 counts at all rates, R6 distinct streams
    block(2'd0, 20);
    block(2'd1, 40);
    block(2'd2, 40);
    block(2'd3, 64);

    // R7 with back-pressure
    begin
      int base;
      set_rate(2'd0);
      set_rate(2'd2);
      base = n_out;
      bp_on = 1;
      for (int s = 0; s < 64; s++) send(nextv(), nextv());
      drain();
      check(n_out - base == 16, "R7 count under back-pressure", n_out - base, 16);
    end

    // R8: rate change clears phase
    begin
      int base;
      set_rate(2'd1);
      for (int s = 0; s < 3; s++) send(nextv(), nextv());
      drain();
      set_rate(2'd3);
      set_rate(2'd1);
      base = n_out;
      send(nextv(), nextv());
      drain();
      check(n_out == base, "R8 phase cleared, no output", n_out - base, 0);
      send(nextv(), nextv());
      drain();
      check(n_out - base == 1, "R8 output on second sample", n_out - base, 1);
    end

    // R9: saturation in both directions
    set_rate(2'd0);
    set_rate(2'd1);
    send(0, 0);
    send(-32768, 32767);
    for (int s = 0; s < 5; s++) send(32767, -32768);
    send(-32768, 32767);
    drain();
    check(last_i == 16'sd32767, "R9 positive clamp", last_i, 32767);
    check(last_q == -16'sd32768, "R9 negative clamp", last_q, -32768);

    finish_run();
  end
endmodule